// File: doc/BRIEF.md
# Reduced Operation-Set ALU

A purely combinational two-operand arithmetic unit for a small accumulator-style processor with a 10-bit data path. One operand is always the data register; the other arrives from an upstream multiplexer that picks either the address register or the word read from data memory. The ALU cannot tell which source it received, and it treats both the same way. Six control bits taken from the instruction select the result. The result goes back to the registers and to memory. Two flags, zero and negative, go to the branch-decision logic.

The control word follows the usual scheme for this kind of ALU. Each operand can be cleared, then inverted. Next, the two conditioned operands are either summed or combined through a restricted pass path. Finally, the output can be inverted. Sixteen functions are supported: three constants, the two operands and their complements and negations, increments and decrements of each operand, the sum, and both differences. General bitwise AND and OR of the two operands are deliberately left out to save logic. Any control word that would need them gives a defined zero result.

Top module: `lite_alu`

## Requirements
- R1: Control words 6'b101010, 6'b111111 and 6'b111010 give 0, 1 and all-ones (-1) respectively, whatever the operands are. The control bits, MSB first, are clear-x, invert-x, clear-y, invert-y, sum-select and invert-output.
- R2: Control words 6'b001100, 6'b110000, 6'b001101 and 6'b110001 give D, Y, bitwise NOT D and bitwise NOT Y.
- R3: Control words 6'b001111 and 6'b110011 give the two's complement negation of D and of Y.
- R4: Control words 6'b011111, 6'b110111, 6'b001110 and 6'b110010 give D+1, Y+1, D-1 and Y-1.
- R5: Control words 6'b000010, 6'b010011 and 6'b000111 give D+Y, D-Y and Y-D.
- R6: All arithmetic is modulo 2^10. A carry or borrow out of bit 9 is dropped (511+1 gives 512; 1023+1 gives 0).
- R7: A control word with sum-select low, where neither conditioned operand is forced to all-ones (clear and invert both set for the same operand), gives a result of 0. This includes 6'b000000 (would be D AND Y) and 6'b010101 (would be D OR Y).
- R8: The zero flag is high exactly when all ten result bits are 0.
- R9: The negative flag equals result bit 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_d | input | 10 | First operand, from the data register |
| opd_y | input | 10 | Second operand, address register or memory word |
| ctl | input | 6 | Function control bits, MSB first: clear-x, invert-x, clear-y, invert-y, sum-select, invert-output |
| res | output | 10 | Function result |
| zero | output | 1 | High when res is all zeros |
| neg | output | 1 | Copy of res bit 9 |

## Verification
The flags and the modular wraparound act in the same evaluation, because the flags are taken from the already truncated result. The bench provokes this with a sum that carries into the sign bit (511+1), an increment of all-ones that wraps to zero, and a difference that borrows through zero. In each case the result and both flags are compared with values computed from the arithmetic meaning of the function. The unsupported-code fallback is judged the same way: its zero result has to raise the zero flag even when the operands are all-ones.

// File: rtl/lite_alu_pkg.sv
package lite_alu_pkg;

    // Control word, MSB first as it appears in the instruction
    typedef struct packed {
        logic clr_x;
        logic inv_x;
        logic clr_y;
        logic inv_y;
        logic sum_sel;
        logic inv_out;
    } alu_ctl_t;

    localparam int CTL_W = $bits(alu_ctl_t);

endpackage

// File: rtl/lite_alu_cond.sv
module lite_alu_cond #(
    parameter int W = 10
) (
    input  logic [W-1:0] opd_i,
    input  logic         clr_i,
    input  logic         inv_i,
    output logic [W-1:0] opd_o,
    output logic         ones_o
);
    logic [W-1:0] clr_d;

    always_comb begin
        clr_d  = clr_i ? '0 : opd_i;
        opd_o  = inv_i ? ~clr_d : clr_d;
        // operand forced to all-ones regardless of input value
        ones_o = clr_i & inv_i;
    end
endmodule

// File: rtl/lite_alu_core.sv
module lite_alu_core #(
    parameter int W = 10
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         x_ones_i,
    input  logic         y_ones_i,
    input  logic         sum_sel_i,
    output logic [W-1:0] core_o,
    output logic         kill_o
);
    always_comb begin
        core_o = '0;
        kill_o = 1'b0;
        if (sum_sel_i) begin
            core_o = x_i + y_i;
        end else if (y_ones_i) begin
            core_o = x_i;
        end else if (x_ones_i) begin
            core_o = y_i;
        end else begin
            kill_o = 1'b1;
        end
    end
endmodule

// File: rtl/lite_alu_post.sv
module lite_alu_post #(
    parameter int W = 10
) (
    input  logic [W-1:0] core_i,
    input  logic         kill_i,
    input  logic         inv_out_i,
    output logic [W-1:0] res_o,
    output logic         zero_o,
    output logic         neg_o
);
    logic [W-1:0] res_d;

    always_comb begin
        if (kill_i)         res_d = '0;
        else if (inv_out_i) res_d = ~core_i;
        else                res_d = core_i;
        res_o  = res_d;
        zero_o = ~|res_d;
        neg_o  = res_d[W-1];
    end
endmodule

// File: rtl/lite_alu.sv
module lite_alu
    import lite_alu_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0]     opd_d,
    input  logic [W-1:0]     opd_y,
    input  logic [CTL_W-1:0] ctl,
    output logic [W-1:0]     res,
    output logic             zero,
    output logic             neg
);
    localparam int NOPD = 2;

    alu_ctl_t     ctl_d;
    logic [W-1:0] raw_d  [NOPD];
    logic [W-1:0] cnd_d  [NOPD];
    logic         ones_d [NOPD];
    logic         clr_d  [NOPD];
    logic         inv_d  [NOPD];
    logic [W-1:0] core_d;
    logic         kill_d;

    always_comb begin
        ctl_d    = alu_ctl_t'(ctl);
        raw_d[0] = opd_d;
        raw_d[1] = opd_y;
        clr_d[0] = ctl_d.clr_x;
        inv_d[0] = ctl_d.inv_x;
        clr_d[1] = ctl_d.clr_y;
        inv_d[1] = ctl_d.inv_y;
    end

    for (genvar g = 0; g < NOPD; g++) begin : g_cond
        lite_alu_cond #(.W(W)) u_cond (
            .opd_i (raw_d[g]),
            .clr_i (clr_d[g]),
            .inv_i (inv_d[g]),
            .opd_o (cnd_d[g]),
            .ones_o(ones_d[g])
        );
    end

    lite_alu_core #(.W(W)) u_core (
        .x_i      (cnd_d[0]),
        .y_i      (cnd_d[1]),
        .x_ones_i (ones_d[0]),
        .y_ones_i (ones_d[1]),
        .sum_sel_i(ctl_d.sum_sel),
        .core_o   (core_d),
        .kill_o   (kill_d)
    );

    lite_alu_post #(.W(W)) u_post (
        .core_i   (core_d),
        .kill_i   (kill_d),
        .inv_out_i(ctl_d.inv_out),
        .res_o    (res),
        .zero_o   (zero),
        .neg_o    (neg)
    );
endmodule

// File: rtl/lite_alu_chk.sv
module lite_alu_chk #(
    parameter int W = 10
) (
    input logic [W-1:0] opd_d,
    input logic [W-1:0] opd_y,
    input logic [5:0]   ctl,
    input logic [W-1:0] res,
    input logic         zero,
    input logic         neg
);
    logic known;
    logic unsup;

    always_comb begin
        known = !$isunknown({opd_d, opd_y, ctl, res, zero, neg});
        unsup = !ctl[1] && !(ctl[3] && ctl[2]) && !(ctl[5] && ctl[4]);
        if (known) begin
            AST_CONST_ONE: assert (ctl != 6'b111111 || res == W'(1)) else $error("one"); // R1
            AST_PASS_D: assert (ctl != 6'b001100 || res == opd_d) else $error("pass d"); // R2
            AST_NEG_D: assert (ctl != 6'b001111 || res == W'(-opd_d)) else $error("neg d"); // R3
            AST_SUM: assert (ctl != 6'b000010 || res == W'(opd_d + opd_y)) else $error("sum"); // R5
            AST_UNSUP_ZERO: assert (!unsup || res == '0) else $error("fallback"); // R7
            AST_ZERO_FLAG: assert (zero == (res == '0)) else $error("zero flag"); // R8
            AST_NEG_FLAG: assert (neg == res[W-1]) else $error("neg flag"); // R9
        end
    end
endmodule

bind lite_alu lite_alu_chk #(.W(W)) u_chk (
    .opd_d(opd_d),
    .opd_y(opd_y),
    .ctl  (ctl),
    .res  (res),
    .zero (zero),
    .neg  (neg)
);

// File: tb/sim_lite_alu.sv
module sim_lite_alu;
    localparam int W = 10;
    localparam logic [W-1:0] MASK = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] opd_d = '0;
    logic [W-1:0] opd_y = '0;
    logic [5:0]   ctl = 6'b101010;
    logic [W-1:0] res;
    logic         zero;
    logic         neg;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lite_alu #(.W(W)) u0 (
        .opd_d(opd_d), .opd_y(opd_y), .ctl(ctl),
        .res(res), .zero(zero), .neg(neg)
    );

    // {control, d, y, expected result}
    localparam int NV = 14;
    localparam logic [35:0] VEC [NV] = '{
        {6'b101010, 10'd5,    10'd9,   10'd0},
        {6'b111111, 10'd5,    10'd9,   10'd1},
        {6'b111010, 10'd5,    10'd9,   10'd1023},
        {6'b001100, 10'd300,  10'd7,   10'd300},
        {6'b110000, 10'd300,  10'd7,   10'd7},
        {6'b001101, 10'd0,    10'd7,   10'd1023},
        {6'b110011, 10'd0,    10'd1,   10'd1023},
        {6'b000010, 10'd511,  10'd1,   10'd512},
        {6'b010011, 10'd3,    10'd5,   10'd1022},
        {6'b000111, 10'd3,    10'd5,   10'd2},
        {6'b011111, 10'd1023, 10'd0,   10'd0},
        {6'b110010, 10'd0,    10'd0,   10'd1023},
        {6'b000000, 10'd1023, 10'd1023, 10'd0},
        {6'b010101, 10'd5,    10'd3,   10'd0}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1, 2:   return "R1";
            3, 4, 5:   return "R2";
            6:         return "R3";
            7, 10:     return "R6";
            8, 9:      return "R5";
            11:        return "R4";
            default:   return "R7";
        endcase
    endfunction

    // the sixteen supported controls, indexed by function id
    localparam logic [5:0] CODES [16] = '{
        6'b101010, 6'b111111, 6'b111010, 6'b001100,
        6'b110000, 6'b001101, 6'b110001, 6'b001111,
        6'b110011, 6'b011111, 6'b110111, 6'b001110,
        6'b110010, 6'b000010, 6'b010011, 6'b000111
    };

    function automatic logic [W-1:0] ref_fn(int id, logic [W-1:0] d, logic [W-1:0] y);
        case (id)
            0:  return '0;
            1:  return W'(1);
            2:  return MASK;
            3:  return d;
            4:  return y;
            5:  return ~d;
            6:  return ~y;
            7:  return W'(0 - d);
            8:  return W'(0 - y);
            9:  return W'(d + 1);
            10: return W'(y + 1);
            11: return W'(d - 1);
            12: return W'(y - 1);
            13: return W'(d + y);
            14: return W'(d - y);
            default: return W'(y - d);
        endcase
    endfunction

    function automatic string fn_tag(int id);
        if (id <= 2)  return "R1";
        if (id <= 6)  return "R2";
        if (id <= 8)  return "R3";
        if (id <= 12) return "R4";
        return "R5";
    endfunction

    task automatic apply(logic [5:0] c, logic [W-1:0] d, logic [W-1:0] y);
        @(negedge clk);
        ctl = c; opd_d = d; opd_y = y;
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(string tag, logic [W-1:0] exp);
        checks++;
        if (res !== exp) begin
            errors++;
            $display("FAIL %s ctl=%b d=%0d y=%0d res=%0d expected %0d", tag, ctl, opd_d, opd_y, res, exp);
        end
        checks++;
        if (zero !== (exp == '0)) begin
            errors++;
            $display("FAIL R8 ctl=%b zero=%b expected %b", ctl, zero, exp == '0);
        end
        checks++;
        if (neg !== exp[W-1]) begin
            errors++;
            $display("FAIL R9 ctl=%b neg=%b expected %b", ctl, neg, exp[W-1]);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: done=%b expected 1", done);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] rd;
        logic [W-1:0] ry;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // reset state: constant-zero control with zero operands (R1)
        check_all("R1", '0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][35:30], VEC[i][29:20], VEC[i][19:10]);
            check_all(vec_tag(i), VEC[i][9:0]);
        end

        // randomized sweep of every supported function
        for (int id = 0; id < 16; id++) begin
            for (int k = 0; k < 40; k++) begin
                rd = W'($urandom);
                ry = W'($urandom);
                apply(CODES[id], rd, ry);
                check_all(fn_tag(id), ref_fn(id, rd, ry));
            end
        end

        // corner cases: wraparound into sign and through zero (R6)
        apply(6'b000010, 10'd1023, 10'd1);
        check_all("R6", '0);
        apply(6'b010011, 10'd0, 10'd1);
        check_all("R6", MASK);
        apply(6'b110111, 10'd511, 10'd511);
        check_all("R6", 10'd512);
        apply(6'b001111, 10'd512, 10'd0);
        check_all("R3", 10'd512);

        // fallback: every sum-select-low code without a forced all-ones operand (R7)
        for (int c = 0; c < 64; c++) begin
            logic [5:0] cc;
            cc = 6'(c);
            if (!cc[1] && !(cc[3] && cc[2]) && !(cc[5] && cc[4])) begin
                apply(cc, 10'd1023, 10'd1023);
                check_all("R7", '0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule